// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Register

This block is the 64-bit command register a processor core uses to send an interrupt message to other cores. Software fills in the vector, the kind of delivery, the addressing style and the target. The register then produces exactly one message on a valid/ready output port. While that message waits for the fabric to accept it, a read-only status bit in the register reads as 1.

The register can be written in two ways, and the `wide_mode` input picks which one is live. In half-word mode, software writes two 32-bit halves through `wr_hi_en` and `wr_lo_en`. The target is an 8-bit field at bits 63:56. Only the low-half write sends a message, so the high half must be written first. In whole-word mode, one 64-bit write through `wr64_en` loads the register and sends the message, and the target is a 32-bit field at bits 63:32. A nonzero shorthand code replaces the target field: 01 means the sender only, 10 means all cores including the sender, and 11 means all cores except the sender. The fields of each message are captured when it launches, so later writes to the high half cannot change a message that is still in flight.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset, `rd_data` reads all zero, `msg_valid` is 0 and `send_pending` is 0.
- R2: In half-word mode (`wide_mode`=0), a high-half write updates bits 63:32 and produces no message. A low-half write launches a message with the following fields:
  - vector from bits 7:0
  - delivery mode from bits 10:8
  - logical flag from bit 11
  - level from bit 14
  - trigger from bit 15
  - shorthand from bits 19:18
  - destination from bits 63:56, zero-extended to 32 bits
- R3: In whole-word mode (`wide_mode`=1), a 64-bit write loads the register and launches a message with the same low-half fields and with destination from bits 63:32.
- R4: `rd_data` bit 12 always equals `send_pending`, and software writes to bit 12 have no effect. The following bits read as zero:
  - bits 13, 16, 17 and 31:20
  - bits 55:32, in half-word mode only
- R5: A launch sets `send_pending` and `msg_valid` on the next cycle. The message fields hold steady while `msg_ready` is low. The cycle after `msg_valid` and `msg_ready` are both high, `send_pending` and `msg_valid` are 0.
- R6: A launching write that arrives while `send_pending` is 1 is ignored and leaves the low half unchanged. This also applies in the cycle in which the handshake completes.
- R7: A launching write whose delivery mode is the reserved code 3'b011 produces no message, and `send_pending` stays 0. The low half is still stored.
- R8: When the shorthand field is nonzero, `msg_dest` is zero.
- R9: The write port of the inactive mode is ignored: `wr_lo_en`/`wr_hi_en` in whole-word mode, and `wr64_en` in half-word mode.
- R10: A high-half write while a message is pending updates `rd_data` bits 63:32 but does not change `msg_dest` of the pending message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 0: two 32-bit halves; 1: single 64-bit write |
| wr_lo_en | input | 1 | Half-word mode low-half write (launches) |
| wr_hi_en | input | 1 | Half-word mode high-half write |
| wr_data | input | 32 | Half-word write data |
| wr64_en | input | 1 | Whole-word write (launches) |
| wr64_data | input | 64 | Whole-word write data |
| rd_data | output | 64 | Register readback including status bit 12 |
| send_pending | output | 1 | Delivery status: 1 while the last message is unsent |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Fabric accepts the message |
| msg_vector | output | 8 | Interrupt vector |
| msg_dlv_mode | output | 3 | Delivery mode code |
| msg_logical | output | 1 | 1: logical addressing, 0: physical |
| msg_level | output | 1 | 1: assert, 0: de-assert |
| msg_trigger | output | 1 | 1: level trigger, 0: edge |
| msg_shorthand | output | 2 | Destination shorthand code |
| msg_dest | output | 32 | Destination, zero when shorthand is used |

## Verification
A new launching write and the completion of the previous message's handshake can fall in the same cycle. The question is whether the write sees the status from before or after that edge. The bench provokes this by holding a message pending, then raising `msg_ready` and `wr_lo_en` together for a single cycle. It then expects `send_pending` to be 0 with no new message and the old vector still in `rd_data`, which shows the write was judged against the status of 1.

// File: rtl/ipi_cmd_pkg.sv
// Package: field positions, masks and the message type shared by the
// inter-processor interrupt command register and its submodules.
package ipi_cmd_pkg;
    localparam int HALF_W     = 32;
    localparam int CMD_W      = 2 * HALF_W;
    localparam int VEC_W      = 8;
    localparam int DM_W       = 3;
    localparam int SH_W       = 2;
    localparam int NDEST_W    = 8;           // destination width, half-word mode
    localparam int WDEST_W    = HALF_W;      // destination width, whole-word mode

    localparam int VEC_LSB    = 0;
    localparam int DM_LSB     = 8;
    localparam int LOGIC_BIT  = 11;
    localparam int STAT_BIT   = 12;
    localparam int LEVEL_BIT  = 14;
    localparam int TRIG_BIT   = 15;
    localparam int SH_LSB     = 18;

    // Writable low-half bits: 7:0, 10:8, 11, 14, 15, 19:18
    localparam logic [HALF_W-1:0] LO_WMASK = 32'h000C_CFFF;
    // Writable high-half bits in half-word mode: destination at the top
    localparam logic [HALF_W-1:0] HI_NMASK = {{NDEST_W{1'b1}}, {(HALF_W-NDEST_W){1'b0}}};
    localparam logic [DM_W-1:0]   DM_RSVD  = 3'b011;

    typedef struct packed {
        logic [VEC_W-1:0]   vector;
        logic [DM_W-1:0]    dlv_mode;
        logic               logical;
        logic               level;
        logic               trigger;
        logic [SH_W-1:0]    shorthand;
        logic [WDEST_W-1:0] dest;
    } ipi_msg_t;
endpackage

// File: rtl/ipi_cmd_store.sv
// Holds the two register halves. Picks the write port by wide_mode and masks
// reserved bits on entry. Gates the launching half while a message is pending.
// Exposes next-state values so the launcher sees data written in the same cycle.
// Assumes the caller provides the current pending flag.
module ipi_cmd_store
    import ipi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              wr_lo_en,
    input  logic              wr_hi_en,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              wr64_en,
    input  logic [CMD_W-1:0]  wr64_data,
    input  logic              pending,
    output logic [HALF_W-1:0] lo_q,
    output logic [HALF_W-1:0] hi_q,
    output logic [HALF_W-1:0] lo_nxt,
    output logic [HALF_W-1:0] hi_nxt,
    output logic              launch
);
    logic              lo_take, hi_take;
    logic [HALF_W-1:0] lo_src, hi_src, hi_mask;

    // Select the active write port and compute the next register contents
    always_comb begin
        lo_take = wide_mode ? (wr64_en && !pending) : (wr_lo_en && !pending);
        hi_take = wide_mode ? (wr64_en && !pending) : wr_hi_en;
        lo_src  = wide_mode ? wr64_data[HALF_W-1:0] : wr_data;
        hi_src  = wide_mode ? wr64_data[CMD_W-1:HALF_W] : wr_data;
        hi_mask = wide_mode ? {HALF_W{1'b1}} : HI_NMASK;
        lo_nxt  = lo_take ? (lo_src & LO_WMASK) : lo_q;
        hi_nxt  = hi_take ? (hi_src & hi_mask) : hi_q;
        launch  = lo_take;
    end

    // Register both halves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_nxt;
            hi_q <= hi_nxt;
        end
    end
endmodule

// File: rtl/ipi_msg_launch.sv
// Decodes the fields of a launching write into a message and holds it until
// the valid/ready handshake completes. Drops writes with the reserved delivery
// mode. Assumes launch is only raised while no message is pending.
module ipi_msg_launch
    import ipi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              launch,
    input  logic [HALF_W-1:0] lo_nxt,
    input  logic [HALF_W-1:0] hi_nxt,
    input  logic              msg_ready,
    output logic              pending,
    output ipi_msg_t          msg_q
);
    ipi_msg_t msg_d;
    logic     start;
    logic     unused_bits;

    assign unused_bits = ^{lo_nxt[31:20], lo_nxt[17:16], lo_nxt[13:12]};

    // Decode the message fields; a shorthand replaces the destination
    always_comb begin
        msg_d.vector    = lo_nxt[VEC_LSB +: VEC_W];
        msg_d.dlv_mode  = lo_nxt[DM_LSB +: DM_W];
        msg_d.logical   = lo_nxt[LOGIC_BIT];
        msg_d.level     = lo_nxt[LEVEL_BIT];
        msg_d.trigger   = lo_nxt[TRIG_BIT];
        msg_d.shorthand = lo_nxt[SH_LSB +: SH_W];
        if (msg_d.shorthand != '0)
            msg_d.dest = '0;
        else if (wide_mode)
            msg_d.dest = hi_nxt;
        else
            msg_d.dest = {{(WDEST_W-NDEST_W){1'b0}}, hi_nxt[HALF_W-1 -: NDEST_W]};
        start = launch && (msg_d.dlv_mode != DM_RSVD);
    end

    // Pending flag and captured message: set on start, clear on handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            msg_q   <= '0;
        end else if (start) begin
            pending <= 1'b1;
            msg_q   <= msg_d;
        end else if (pending && msg_ready) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/ipi_cmd_reg.sv
// Top of the inter-processor interrupt command register. Joins the register
// store and the message launcher and builds the readback word, with the
// delivery status in bit 12 and reserved bits forced to zero.
// Assumes a synchronous active-low reset.
module ipi_cmd_reg
    import ipi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              wr_lo_en,
    input  logic              wr_hi_en,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              wr64_en,
    input  logic [CMD_W-1:0]  wr64_data,
    output logic [CMD_W-1:0]  rd_data,
    output logic              send_pending,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [VEC_W-1:0]  msg_vector,
    output logic [DM_W-1:0]   msg_dlv_mode,
    output logic              msg_logical,
    output logic              msg_level,
    output logic              msg_trigger,
    output logic [SH_W-1:0]   msg_shorthand,
    output logic [WDEST_W-1:0] msg_dest
);
    logic [HALF_W-1:0] lo_q, hi_q, lo_nxt, hi_nxt;
    logic              launch, pending;
    ipi_msg_t          msg_q;

    ipi_cmd_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide_mode (wide_mode),
        .wr_lo_en  (wr_lo_en),
        .wr_hi_en  (wr_hi_en),
        .wr_data   (wr_data),
        .wr64_en   (wr64_en),
        .wr64_data (wr64_data),
        .pending   (pending),
        .lo_q      (lo_q),
        .hi_q      (hi_q),
        .lo_nxt    (lo_nxt),
        .hi_nxt    (hi_nxt),
        .launch    (launch)
    );

    ipi_msg_launch u_launch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide_mode (wide_mode),
        .launch    (launch),
        .lo_nxt    (lo_nxt),
        .hi_nxt    (hi_nxt),
        .msg_ready (msg_ready),
        .pending   (pending),
        .msg_q     (msg_q)
    );

    // Readback word and message outputs
    always_comb begin
        rd_data[HALF_W-1:0]     = lo_q | (HALF_W'(pending) << STAT_BIT);
        rd_data[CMD_W-1:HALF_W] = hi_q & (wide_mode ? {HALF_W{1'b1}} : HI_NMASK);
        send_pending  = pending;
        msg_valid     = pending;
        msg_vector    = msg_q.vector;
        msg_dlv_mode  = msg_q.dlv_mode;
        msg_logical   = msg_q.logical;
        msg_level     = msg_q.level;
        msg_trigger   = msg_q.trigger;
        msg_shorthand = msg_q.shorthand;
        msg_dest      = msg_q.dest;
    end
endmodule

// File: rtl/ipi_cmd_reg_chk.sv
// Checker for ipi_cmd_reg, attached by bind. Watches ports only.
module ipi_cmd_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wide_mode,
    input logic        wr_lo_en,
    input logic [2:0]  wr_dm,
    input logic        wr64_en,
    input logic [2:0]  wr64_dm,
    input logic        msg_ready,
    input logic        msg_valid,
    input logic        send_pending,
    input logic [7:0]  msg_vector,
    input logic [1:0]  msg_shorthand,
    input logic [31:0] msg_dest,
    input logic [55:0] rd_data
);
    logic try_launch, try_rsvd;
    assign try_launch = wide_mode ? wr64_en : wr_lo_en;
    assign try_rsvd   = try_launch && ((wide_mode ? wr64_dm : wr_dm) == 3'b011);

    // R4
    status_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[12] == send_pending && msg_valid == send_pending);
    // R4
    narrow_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode |-> rd_data[55:32] == '0);
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_dest));
    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready |=> !send_pending);
    // R6
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_pending && try_launch |=> $stable({rd_data[31:13], rd_data[11:0]}));
    // R7
    rsvd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !send_pending && try_rsvd |=> !send_pending);
    // R8
    shorthand_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_shorthand != 2'b00 |-> msg_dest == '0);
endmodule

bind ipi_cmd_reg ipi_cmd_reg_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wide_mode     (wide_mode),
    .wr_lo_en      (wr_lo_en),
    .wr_dm         (wr_data[10:8]),
    .wr64_en       (wr64_en),
    .wr64_dm       (wr64_data[10:8]),
    .msg_ready     (msg_ready),
    .msg_valid     (msg_valid),
    .send_pending  (send_pending),
    .msg_vector    (msg_vector),
    .msg_shorthand (msg_shorthand),
    .msg_dest      (msg_dest),
    .rd_data       (rd_data[55:0])
);

// File: tb/ipi_cmd_reg_test.sv
// Directed bench for ipi_cmd_reg: one task per scenario.
module ipi_cmd_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic        wr_lo_en = 1'b0, wr_hi_en = 1'b0, wr64_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [63:0] wr64_data = '0;
    logic        msg_ready = 1'b0;
    logic [63:0] rd_data;
    logic        send_pending, msg_valid, msg_logical, msg_level, msg_trigger;
    logic [7:0]  msg_vector;
    logic [2:0]  msg_dlv_mode;
    logic [1:0]  msg_shorthand;
    logic [31:0] msg_dest;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    ipi_cmd_reg uut (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
        .wr_lo_en(wr_lo_en), .wr_hi_en(wr_hi_en), .wr_data(wr_data),
        .wr64_en(wr64_en), .wr64_data(wr64_data), .rd_data(rd_data),
        .send_pending(send_pending), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_vector(msg_vector), .msg_dlv_mode(msg_dlv_mode),
        .msg_logical(msg_logical), .msg_level(msg_level),
        .msg_trigger(msg_trigger), .msg_shorthand(msg_shorthand),
        .msg_dest(msg_dest)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // One clock with the given write strobes, then idle; returns at negedge
    task automatic wr_half(input logic lo, input logic hi, input logic [31:0] d);
        @(negedge clk);
        wr_lo_en = lo; wr_hi_en = hi; wr_data = d;
        @(negedge clk);
        wr_lo_en = 1'b0; wr_hi_en = 1'b0;
    endtask

    task automatic wr_full(input logic [63:0] d);
        @(negedge clk);
        wr64_en = 1'b1; wr64_data = d;
        @(negedge clk);
        wr64_en = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "rd_data", rd_data, 64'h0);
        chk("R1", "msg_valid", {63'h0, msg_valid}, 64'h0);
        chk("R1", "send_pending", {63'h0, send_pending}, 64'h0);
    endtask

    task automatic t_narrow();
        wide_mode = 1'b0;
        wr_half(1'b0, 1'b1, 32'hA5FF_FFFF);
        chk("R2", "no msg on high write", {63'h0, msg_valid}, 64'h0);
        chk("R4", "narrow high readback", rd_data[63:32], 64'hA500_0000);
        // vector 41, INIT(101), logical, bit12/13/16 set, level, trigger
        wr_half(1'b1, 1'b0, 32'h0001_FD41);
        chk("R2", "valid", {63'h0, msg_valid}, 64'h1);
        chk("R2", "vector", msg_vector, 64'h41);
        chk("R2", "dlv_mode", msg_dlv_mode, 64'h5);
        chk("R2", "flags", {msg_logical, msg_level, msg_trigger}, 64'h7);
        chk("R2", "dest", msg_dest, 64'hA5);
        chk("R4", "low readback", rd_data[31:0], 64'h0000_DD41);
        repeat (2) @(negedge clk);
        chk("R5", "held without ready", {msg_valid, msg_vector}, {55'h0, 1'b1, 8'h41});
        wr_half(1'b0, 1'b1, 32'h3C00_0000);
        chk("R10", "high readback while pending", rd_data[63:32], 64'h3C00_0000);
        chk("R10", "in-flight dest", msg_dest, 64'hA5);
        wr_half(1'b1, 1'b0, 32'h0000_0022);
        chk("R6", "busy write ignored", rd_data[7:0], 64'h41);
        chk("R6", "still pending", {63'h0, send_pending}, 64'h1);
        drain();
        chk("R5", "cleared after handshake", {62'h0, msg_valid, rd_data[12]}, 64'h0);
    endtask

    task automatic t_collide();
        wide_mode = 1'b0;
        wr_half(1'b1, 1'b0, 32'h0000_0061);
        chk("R5", "pending before collision", {63'h0, send_pending}, 64'h1);
        @(negedge clk);
        msg_ready = 1'b1; wr_lo_en = 1'b1; wr_data = 32'h0000_0077;
        @(negedge clk);
        msg_ready = 1'b0; wr_lo_en = 1'b0;
        chk("R6", "collision: no new msg", {63'h0, send_pending}, 64'h0);
        chk("R6", "collision: low unchanged", rd_data[7:0], 64'h61);
    endtask

    task automatic t_wide();
        wide_mode = 1'b1;
        wr_half(1'b1, 1'b1, 32'h0000_0033);
        chk("R9", "half write ignored in wide mode", {63'h0, msg_valid}, 64'h0);
        wr_full(64'h1234_5678_0000_0023);
        chk("R3", "valid", {63'h0, msg_valid}, 64'h1);
        chk("R3", "vector", msg_vector, 64'h23);
        chk("R3", "dest", msg_dest, 64'h1234_5678);
        chk("R3", "readback", rd_data, 64'h1234_5678_0000_1023);
        drain();
        wr_full(64'hDEAD_BEEF_0008_0030);
        chk("R8", "shorthand", msg_shorthand, 64'h2);
        chk("R8", "dest forced zero", msg_dest, 64'h0);
        drain();
        wide_mode = 1'b0;
        #1;
        chk("R4", "narrow masks 55:32", rd_data[63:32], 64'hDE00_0000);
    endtask

    task automatic t_reserved_and_port();
        wide_mode = 1'b0;
        wr_half(1'b1, 1'b0, 32'h0000_0355);
        chk("R7", "reserved mode no msg", {63'h0, send_pending}, 64'h0);
        chk("R7", "low still stored", rd_data[10:0], 64'h355);
        wr_full(64'h0000_0000_0000_0011);
        chk("R9", "wr64 ignored in half mode", {63'h0, msg_valid}, 64'h0);
        chk("R9", "wr64 left register", rd_data[7:0], 64'h55);
    endtask

    initial begin
        #(8 * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_narrow();
        t_collide();
        t_wide();
        t_reserved_and_port();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule